// File: doc/BRIEF.md
# Banked Cache Identification Registers

This block is a read/write register slice on a 32-bit register bus. Software reads it to learn the cache layout of the core: a constant cache level word, a constant cache type word, and one of sixteen cache size descriptors. A cache size selection register chooses which descriptor the size word returns. The bus carries a 12-bit byte offset, write data, write and read strobes, and a security attribute.

The selection register has two copies. One serves secure accesses and the other serves non-secure accesses. Each access reads or writes only the copy that matches its attribute. The 4-bit value held in a copy is the index into the descriptor table. If the cache-type field of the level word reports no caches, the selection register reads as zero and ignores writes. The constant words and the table are module parameters.

Top module: `cache_id_regs`

## Requirements
- R1: A read at offset 0xD78 returns the LEVEL_WORD parameter on rdata_o in the cycle after the read strobe.
- R2: A read at offset 0xD7C returns the TYPE_WORD parameter in the cycle after the read strobe.
- R3: There are two selection copies, picked by secure_i (1 = secure copy, 0 = non-secure copy). A write to one copy leaves the other copy unchanged.
- R4: A write at offset 0xD84 stores only wdata_i[3:0] into the addressed copy. A read at 0xD84 returns that copy as the low 4 bits, with bits [31:4] zero.
- R5: A read at offset 0xD80 returns table entry k, where k is the 4-bit value in the copy that matches secure_i. Entry k sits at bits [32k+31:32k] of DESC_TABLE, and every k from 0 to 15 can be reached.
- R6: When LEVEL_WORD[20:0] is zero, reads at 0xD84 return zero, writes at 0xD84 have no effect, and reads at 0xD80 return entry 0.
- R7: Writes at offsets 0xD78, 0xD7C and 0xD80 change neither the values read back there nor either selection copy.
- R8: While rst_ni is low, both selection copies are cleared to zero. rst_ni is asynchronous and active low.
- R9: rdata_o is registered. In any cycle after one with re_i low, it is zero. A read at any offset other than the four listed returns zero.
- R10: When a read and a write at 0xD84 occur in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| secure_i | input | 1 | Security attribute of the access, 1 = secure |
| rdata_o | output | 32 | Registered read data |

## Verification
Different index values are written through the two security attributes, and the size word is then read back under each attribute. This separates correct banking from the case where the two copies are swapped or shared. Each table entry is distinct, and index 15 is checked as well, so a wrong or truncated index shows up as a wrong descriptor. Writes are made with all upper bits set, to show that masking works. Writes are also made to the read-only offsets and to offsets outside the map. A second instance, whose level word reports no caches, checks the read-as-zero and write-ignored behaviour and the fall back to entry 0. Finally, a same-cycle read and write separates the old value from the new one.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int CID_DATA_W   = 32;
  localparam int CID_ADDR_W   = 12;
  localparam int CID_IDX_W    = 4;
  localparam int CID_NUM_DESC = 1 << CID_IDX_W;
  localparam int CID_CTYPE_W  = 21;
  localparam int CID_NUM_BANK = 2;

  localparam logic [CID_ADDR_W-1:0] OFS_LEVEL  = 12'hD78;
  localparam logic [CID_ADDR_W-1:0] OFS_TYPE   = 12'hD7C;
  localparam logic [CID_ADDR_W-1:0] OFS_SIZE   = 12'hD80;
  localparam logic [CID_ADDR_W-1:0] OFS_SELECT = 12'hD84;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_LEVEL,
    REG_TYPE,
    REG_SIZE,
    REG_SELECT
  } reg_sel_e;

  function automatic logic [CID_DATA_W*CID_NUM_DESC-1:0] default_table();
    logic [CID_DATA_W*CID_NUM_DESC-1:0] tbl;
    tbl = '0;
    for (int k = 0; k < CID_NUM_DESC; k++) begin
      tbl[k*CID_DATA_W +: CID_DATA_W] = 32'h7000_E01A + (32'(k) << 13);
    end
    return tbl;
  endfunction
endpackage

// File: rtl/cid_decode.sv
module cid_decode
  import cid_pkg::*;
#(
  parameter int ADDR_W = CID_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_LEVEL):  sel_o = REG_LEVEL;
      ADDR_W'(OFS_TYPE):   sel_o = REG_TYPE;
      ADDR_W'(OFS_SIZE):   sel_o = REG_SIZE;
      ADDR_W'(OFS_SELECT): sel_o = REG_SELECT;
      default:             sel_o = REG_NONE;
    endcase
  end
endmodule

// File: rtl/cid_sel_bank.sv
module cid_sel_bank
  import cid_pkg::*;
#(
  parameter int IDX_W    = CID_IDX_W,
  parameter int NUM_BANK = CID_NUM_BANK,
  parameter bit RAZWI    = 1'b0,
  localparam int BANK_W  = $clog2(NUM_BANK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [IDX_W-1:0] wdata_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] bank_q [NUM_BANK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANK; b++) bank_q[b] <= '0;
    end else if (wr_i && !RAZWI) begin
      for (int b = 0; b < NUM_BANK; b++) begin
        if (bank_i == BANK_W'(b)) bank_q[b] <= wdata_i;
      end
    end
  end

  // read-as-zero collapses the index so entry 0 is seen
  assign idx_o = RAZWI ? '0 : bank_q[bank_i];

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_chk
    AST_BANK_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !RAZWI && bank_i == BANK_W'(g)) |=> bank_q[g] == $past(wdata_i)) // R4
      else $error("bank store");
    AST_BANK_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && bank_i != BANK_W'(g)) |=> $stable(bank_q[g])) // R3
      else $error("bank isolate");
    AST_RAZWI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && RAZWI) |=> $stable(bank_q[g])) // R6
      else $error("razwi hold");
  end
endmodule

// File: rtl/cid_desc_mux.sv
module cid_desc_mux
  import cid_pkg::*;
#(
  parameter int DATA_W   = CID_DATA_W,
  parameter int IDX_W    = CID_IDX_W,
  localparam int NUM_DESC = 1 << IDX_W,
  parameter logic [DATA_W*NUM_DESC-1:0] TABLE = '0
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] desc_o
);
  logic [DATA_W-1:0] desc_arr [NUM_DESC];

  for (genvar k = 0; k < NUM_DESC; k++) begin : g_ent
    assign desc_arr[k] = TABLE[k*DATA_W +: DATA_W];
  end

  assign desc_o = desc_arr[idx_i];
endmodule

// File: rtl/cache_id_regs.sv
module cache_id_regs
  import cid_pkg::*;
#(
  parameter int ADDR_W = CID_ADDR_W,
  parameter int DATA_W = CID_DATA_W,
  parameter logic [DATA_W-1:0] LEVEL_WORD = 32'h0920_0003,
  parameter logic [DATA_W-1:0] TYPE_WORD  = 32'h8303_C003,
  parameter logic [DATA_W*CID_NUM_DESC-1:0] DESC_TABLE = cid_pkg::default_table()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              secure_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = CID_IDX_W;
  localparam bit RAZWI = (LEVEL_WORD[CID_CTYPE_W-1:0] == '0);

  reg_sel_e          sel;
  logic              sel_wr;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] desc;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:IDX_W];

  cid_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign sel_wr = we_i && (sel == REG_SELECT);

  cid_sel_bank #(
    .IDX_W    (IDX_W),
    .NUM_BANK (CID_NUM_BANK),
    .RAZWI    (RAZWI)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sel_wr),
    .bank_i  (secure_i),
    .wdata_i (wdata_i[IDX_W-1:0]),
    .idx_o   (idx)
  );

  cid_desc_mux #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .TABLE  (DESC_TABLE)
  ) u_mux (
    .idx_i  (idx),
    .desc_o (desc)
  );

  always_comb begin
    unique case (sel)
      REG_LEVEL:  rd_next = LEVEL_WORD;
      REG_TYPE:   rd_next = TYPE_WORD;
      REG_SIZE:   rd_next = desc;
      REG_SELECT: rd_next = DATA_W'(idx);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rd_next : '0;
  end

  assign rdata_o = rdata_q;

  AST_LEVEL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADDR_W'(OFS_LEVEL)) |=> rdata_o == LEVEL_WORD) // R1
    else $error("level read");
  AST_TYPE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADDR_W'(OFS_TYPE)) |=> rdata_o == TYPE_WORD) // R2
    else $error("type read");
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> rdata_o == '0) // R9
    else $error("idle zero");
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == REG_NONE) |=> rdata_o == '0) // R9
    else $error("unmapped zero");
  AST_SELECT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == REG_SELECT) |=> rdata_o[DATA_W-1:IDX_W] == '0) // R4
    else $error("select upper");
  AST_RAZ_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RAZWI && re_i && sel == REG_SELECT) |=> rdata_o == '0) // R6
    else $error("raz select");
  AST_RAZ_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RAZWI && re_i && sel == REG_SIZE) |=> rdata_o == DESC_TABLE[DATA_W-1:0]) // R6
    else $error("raz size");
endmodule

// File: tb/cache_id_regs_bench.sv
`timescale 1ns/1ps
module cache_id_regs_bench;
  localparam logic [31:0] LVL    = 32'h0920_0003;
  localparam logic [31:0] LVL_NC = 32'h0920_0000;
  localparam logic [31:0] TYP    = 32'h8303_C003;

  function automatic logic [31:0] tb_desc(input int k);
    return 32'h8000_0000 | (32'(k) << 20) | 32'(k * 3 + 1);
  endfunction

  function automatic logic [511:0] tb_table();
    logic [511:0] t;
    for (int k = 0; k < 16; k++) t[k*32 +: 32] = tb_desc(k);
    return t;
  endfunction

  localparam logic [511:0] TBL = tb_table();

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic        secure_i = 1'b0;
  logic [31:0] rdata_o;
  logic [31:0] rdata_nc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cache_id_regs #(.LEVEL_WORD(LVL), .TYPE_WORD(TYP), .DESC_TABLE(TBL)) u_cache_id_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .secure_i, .rdata_o
  );

  cache_id_regs #(.LEVEL_WORD(LVL_NC), .TYPE_WORD(TYP), .DESC_TABLE(TBL)) u_cache_id_regs_nc (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .secure_i, .rdata_o(rdata_nc)
  );

  typedef struct packed {
    logic        we;
    logic        re;
    logic        sec;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b0, 12'hD78, 32'h0,         LVL,        8'd1},  // R1
    '{1'b0, 1'b1, 1'b1, 12'hD7C, 32'h0,         TYP,        8'd2},  // R2
    '{1'b1, 1'b0, 1'b0, 12'hD84, 32'hFFFF_FFF5, 32'h0,      8'd9},  // R9 idle
    '{1'b0, 1'b1, 1'b0, 12'hD84, 32'h0,         32'h5,      8'd4},  // R4 mask
    '{1'b0, 1'b1, 1'b1, 12'hD84, 32'h0,         32'h0,      8'd3},  // R3 other bank
    '{1'b1, 1'b0, 1'b1, 12'hD84, 32'h0000_00FA, 32'h0,      8'd9},
    '{1'b0, 1'b1, 1'b1, 12'hD84, 32'h0,         32'hA,      8'd3},  // R3
    '{1'b0, 1'b1, 1'b0, 12'hD84, 32'h0,         32'h5,      8'd3},  // R3 untouched
    '{1'b0, 1'b1, 1'b1, 12'hD80, 32'h0,         tb_desc(10), 8'd5}, // R5
    '{1'b0, 1'b1, 1'b0, 12'hD80, 32'h0,         tb_desc(5), 8'd5},  // R5
    '{1'b1, 1'b0, 1'b0, 12'hD80, 32'h0,         32'h0,      8'd7},  // R7
    '{1'b1, 1'b0, 1'b0, 12'hD78, 32'h1234_5678, 32'h0,      8'd7},
    '{1'b1, 1'b0, 1'b1, 12'hD7C, 32'hFFFF_FFFF, 32'h0,      8'd7},
    '{1'b0, 1'b1, 1'b0, 12'hD80, 32'h0,         tb_desc(5), 8'd7},  // R7
    '{1'b0, 1'b1, 1'b0, 12'hD78, 32'h0,         LVL,        8'd7},  // R7
    '{1'b0, 1'b1, 1'b1, 12'hD7C, 32'h0,         TYP,        8'd7},  // R7
    '{1'b0, 1'b1, 1'b0, 12'h000, 32'h0,         32'h0,      8'd9},  // R9 unmapped
    '{1'b0, 1'b1, 1'b1, 12'hD88, 32'h0,         32'h0,      8'd9},  // R9
    '{1'b1, 1'b1, 1'b0, 12'hD84, 32'h0000_0003, 32'h5,      8'd10}, // R10
    '{1'b0, 1'b1, 1'b0, 12'hD84, 32'h0,         32'h3,      8'd10}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic re, input logic sec,
                    input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = we; re_i = re; secure_i = sec; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R8 reset state
    op(1'b0, 1'b1, 1'b0, 12'hD84, '0); check("R8", rdata_o, 32'h0);
    op(1'b0, 1'b1, 1'b1, 12'hD84, '0); check("R8", rdata_o, 32'h0);
    op(1'b0, 1'b1, 1'b1, 12'hD80, '0); check("R8", rdata_o, tb_desc(0));

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].we, VEC[i].re, VEC[i].sec, VEC[i].addr, VEC[i].wdata);
      check($sformatf("R%0d", VEC[i].req), rdata_o, VEC[i].exp);
    end

    // R5 top index
    op(1'b1, 1'b0, 1'b1, 12'hD84, 32'hF);
    op(1'b0, 1'b1, 1'b1, 12'hD80, '0); check("R5", rdata_o, tb_desc(15));
    op(1'b0, 1'b1, 1'b0, 12'hD80, '0); check("R5", rdata_o, tb_desc(3));

    // R6 no-cache instance
    op(1'b1, 1'b0, 1'b1, 12'hD84, 32'h9);
    op(1'b0, 1'b1, 1'b1, 12'hD84, '0); check("R6", rdata_nc, 32'h0);
    op(1'b0, 1'b1, 1'b0, 12'hD84, '0); check("R6", rdata_nc, 32'h0);
    op(1'b0, 1'b1, 1'b1, 12'hD80, '0); check("R6", rdata_nc, tb_desc(0));
    op(1'b0, 1'b1, 1'b0, 12'hD80, '0); check("R6", rdata_nc, tb_desc(0));
    op(1'b0, 1'b1, 1'b0, 12'hD78, '0); check("R6", rdata_nc, LVL_NC);
    check("R6", rdata_o, LVL);

    // R8 mid-run reset clears both banks
    op(1'b0, 1'b0, 1'b0, 12'h0, '0);
    rst_ni = 1'b0;
    #3;
    rst_ni = 1'b1;
    op(1'b0, 1'b1, 1'b1, 12'hD84, '0); check("R8", rdata_o, 32'h0);
    op(1'b0, 1'b1, 1'b0, 12'hD84, '0); check("R8", rdata_o, 32'h0);
    op(1'b0, 1'b0, 1'b0, 12'h0, '0);   check("R9", rdata_o, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule